// File: doc/BRIEF.md
# Prefix-Aware Register Specifier Decoder

The block takes an instruction byte stream, one byte per clock, under a valid/ready handshake. It picks out the operand-size override byte (66H) and the register-extension prefix (40H-4FH, active in 64-bit mode only). It then reads the primary opcode, the operand-form byte and, when one is needed, the scaled-index byte. When the last byte of an instruction has been taken, it presents for one cycle the instruction class, the resolved operand size and three register specifiers widened to four bits.

A mode input chooses 64-bit or legacy operation. In legacy mode the bytes 40H-4FH are single-byte increment and decrement instructions. In 64-bit mode they are the extension prefix, laid out as 0100WRXB from bit 7 down to bit 0. That prefix counts only if it comes directly before the opcode.

Only a small set of opcodes is supported: 01, 03, 88, 89, 8B, B8+r, and the FF group with extensions 0 and 1. Any other opcode ends the instruction at once and is reported as unsupported. The block does not fetch displacements or immediates.

Top module: `rsd_decoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With mode64=0, byte 40H-47H is an increment (class 6) and 48H-4FH a decrement (class 7). Each is one byte long, with out_base = {0, byte[2:0]}. With mode64=1 these bytes are prefixes and produce no result.
- R3: For any non-byte operation, W=1 (prefix bit 3) gives size code 3 (64 bits), even when 66H is present.
- R4: Without W, a 66H byte gives size code 1 (16 bits). With neither, the size code is 2 (32 bits). This holds in both modes.
- R5: Opcode 88 (class 2) always reports size code 0 (8 bits), whatever W or 66H say.
- R6: For opcodes 01/03/88/89/8B (classes 0/1/2/3/4), out_reg = {R, form[5:3]}, where R is prefix bit 2. For FF, form[5:3]=0 gives class 6 and 1 gives class 7. In both cases R is ignored and out_reg = {0, form[5:3]}.
- R7: When a scaled-index byte is present, out_index = {X, sib[5:3]}, where X is prefix bit 1. Otherwise out_index is 0.
- R8: B (prefix bit 0) is the top bit of out_base. The low bits are sib[2:0] when a scaled-index byte is present, otherwise form[2:0], and for B8+r (class 5) they are opcode[2:0].
- R9: A scaled-index byte follows exactly when form[7:6] != 11 and form[2:0] = 100. out_sib reports its presence.
- R10: A prefix followed by 66H is discarded. When two prefixes appear in a row, the last one wins.
- R11: out_valid is high for exactly one cycle, in the cycle after the last byte of an instruction is accepted. In that cycle in_ready is 0. Otherwise in_ready is 1 and out_valid is 0.
- R12: An unsupported opcode, or FF with form[5:3] > 1, gives class 8 with out_size, out_reg, out_base, out_index and out_sib all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode64 | input | 1 | 1 selects 64-bit mode, 0 selects legacy mode |
| in_valid | input | 1 | An instruction byte is offered |
| in_byte | input | 8 | The instruction byte |
| in_ready | output | 1 | The block can take a byte |
| out_valid | output | 1 | The decode result is valid |
| out_class | output | 4 | Class code: 0-8 as given in the requirements |
| out_size | output | 2 | Size code: 0=8, 1=16, 2=32, 3=64 bits |
| out_reg | output | 4 | Widened register or extension field |
| out_base | output | 4 | Widened base, r/m or opcode-embedded register |
| out_index | output | 4 | Widened index register |
| out_sib | output | 1 | A scaled-index byte was consumed |

## Verification
The hardest cases to reach are prefix orderings in 64-bit mode where an extension prefix is discarded or overridden. One is extension then 66H, where W must be lost. Another is two extension prefixes in a row. A third is an FF group byte whose R bit must be ignored while B still applies. Directed sequences hit each of these. Random instructions then mix the prefix orders with random form and scaled-index bytes. Those random form bytes also hit the case with mod=11 and r/m=100, which must not fetch a scaled-index byte.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
    localparam int BYTE_W = 8;
    localparam int FLD_W  = 3;
    localparam int SPEC_W = FLD_W + 1;
    localparam int CLS_W  = 4;

    typedef enum logic [CLS_W-1:0] {
        C_ADD_MR  = 4'd0,
        C_ADD_RM  = 4'd1,
        C_MOV_MR8 = 4'd2,
        C_MOV_MR  = 4'd3,
        C_MOV_RM  = 4'd4,
        C_MOV_IMM = 4'd5,
        C_INC     = 4'd6,
        C_DEC     = 4'd7,
        C_BAD     = 4'd8,
        C_GRP     = 4'd9
    } cls_e;

    typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ64 = 2'd3} size_e;

    typedef enum logic [1:0] {ST_PFX, ST_FORM, ST_SIDX, ST_OUT} state_e;

    typedef struct packed {
        logic w;
        logic r;
        logic x;
        logic b;
    } wide_t;
endpackage

// File: rtl/rsd_opclass.sv
module rsd_opclass
    import rsd_pkg::*;
(
    input  logic              mode64,
    input  logic [BYTE_W-1:0] op,
    output logic              is_osz,
    output logic              is_wide,
    output logic              needs_form,
    output cls_e              cls
);
    always_comb begin
        is_osz     = (op == 8'h66);
        is_wide    = mode64 && (op[7:4] == 4'h4);
        needs_form = 1'b0;
        cls        = C_BAD;
        if (!mode64 && op[7:4] == 4'h4) begin
            cls = op[3] ? C_DEC : C_INC;
        end else if (op[7:3] == 5'b10111) begin
            cls = C_MOV_IMM;
        end else begin
            case (op)
                8'h01: begin cls = C_ADD_MR;  needs_form = 1'b1; end
                8'h03: begin cls = C_ADD_RM;  needs_form = 1'b1; end
                8'h88: begin cls = C_MOV_MR8; needs_form = 1'b1; end
                8'h89: begin cls = C_MOV_MR;  needs_form = 1'b1; end
                8'h8B: begin cls = C_MOV_RM;  needs_form = 1'b1; end
                8'hFF: begin cls = C_GRP;     needs_form = 1'b1; end
                default: cls = C_BAD;
            endcase
        end
    end
endmodule

// File: rtl/rsd_size.sv
module rsd_size
    import rsd_pkg::*;
(
    input  cls_e  cls,
    input  logic  w,
    input  logic  osz,
    output size_e size
);
    always_comb begin
        if (cls == C_BAD || cls == C_MOV_MR8) size = SZ8;
        else if (w)                           size = SZ64;
        else if (osz)                         size = SZ16;
        else                                  size = SZ32;
    end
endmodule

// File: rtl/rsd_widen.sv
module rsd_widen
    import rsd_pkg::*;
(
    input  cls_e              cls,
    input  logic              from_grp,
    input  wide_t             wb,
    input  logic [FLD_W-1:0]  op_lo,
    input  logic [BYTE_W-1:0] form,
    input  logic [BYTE_W-1:0] sib,
    input  logic              has_sib,
    output logic [SPEC_W-1:0] reg_spec,
    output logic [SPEC_W-1:0] base_spec,
    output logic [SPEC_W-1:0] idx_spec,
    output logic              sib_out
);
    logic no_form;

    always_comb begin
        no_form   = (cls == C_MOV_IMM) ||
                    (!from_grp && (cls == C_INC || cls == C_DEC));
        reg_spec  = '0;
        base_spec = '0;
        idx_spec  = '0;
        sib_out   = 1'b0;
        if (cls != C_BAD) begin
            if (no_form) begin
                base_spec = {wb.b, op_lo};
            end else begin
                reg_spec  = from_grp ? {1'b0, form[5:3]} : {wb.r, form[5:3]};
                base_spec = has_sib ? {wb.b, sib[2:0]} : {wb.b, form[2:0]};
                idx_spec  = has_sib ? {wb.x, sib[5:3]} : '0;
                sib_out   = has_sib;
            end
        end
    end
endmodule

// File: rtl/rsd_decoder.sv
module rsd_decoder
    import rsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode64,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              out_valid,
    output logic [CLS_W-1:0]  out_class,
    output logic [1:0]        out_size,
    output logic [SPEC_W-1:0] out_reg,
    output logic [SPEC_W-1:0] out_base,
    output logic [SPEC_W-1:0] out_index,
    output logic              out_sib
);
    typedef struct packed {
        state_e            st;
        logic              osz;
        wide_t             wb;
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] form;
        logic [BYTE_W-1:0] sib;
        logic              has_sib;
        cls_e              cls;
    } st_t;

    localparam st_t ST_RESET = '{st: ST_PFX, osz: 1'b0, wb: '0, op: '0, form: '0,
                                 sib: '0, has_sib: 1'b0, cls: C_BAD};

    st_t   s_d, s_q;
    logic  take;
    logic  b_osz, b_wide, b_form;
    cls_e  b_cls;
    cls_e  cls_fin;
    size_e size_fin;

    rsd_opclass u_cls (
        .mode64     (mode64),
        .op         (in_byte),
        .is_osz     (b_osz),
        .is_wide    (b_wide),
        .needs_form (b_form),
        .cls        (b_cls)
    );

    always_comb begin
        s_d      = s_q;
        in_ready = (s_q.st != ST_OUT);
        take     = in_valid && in_ready;
        case (s_q.st)
            ST_PFX: if (take) begin
                if (b_osz) begin
                    s_d.osz = 1'b1;
                    s_d.wb  = '0;
                end else if (b_wide) begin
                    s_d.wb = in_byte[3:0];
                end else begin
                    s_d.op  = in_byte;
                    s_d.cls = b_cls;
                    s_d.st  = b_form ? ST_FORM : ST_OUT;
                end
            end
            ST_FORM: if (take) begin
                s_d.form = in_byte;
                if (in_byte[7:6] != 2'b11 && in_byte[2:0] == 3'b100) begin
                    s_d.has_sib = 1'b1;
                    s_d.st      = ST_SIDX;
                end else begin
                    s_d.st = ST_OUT;
                end
            end
            ST_SIDX: if (take) begin
                s_d.sib = in_byte;
                s_d.st  = ST_OUT;
            end
            default: s_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= ST_RESET;
        else        s_q <= s_d;
    end

    always_comb begin
        cls_fin = s_q.cls;
        if (s_q.cls == C_GRP) begin
            case (s_q.form[5:3])
                3'd0:    cls_fin = C_INC;
                3'd1:    cls_fin = C_DEC;
                default: cls_fin = C_BAD;
            endcase
        end
    end

    rsd_size u_size (
        .cls  (cls_fin),
        .w    (s_q.wb.w),
        .osz  (s_q.osz),
        .size (size_fin)
    );

    rsd_widen u_widen (
        .cls       (cls_fin),
        .from_grp  (s_q.cls == C_GRP),
        .wb        (s_q.wb),
        .op_lo     (s_q.op[FLD_W-1:0]),
        .form      (s_q.form),
        .sib       (s_q.sib),
        .has_sib   (s_q.has_sib),
        .reg_spec  (out_reg),
        .base_spec (out_base),
        .idx_spec  (out_index),
        .sib_out   (out_sib)
    );

    assign out_valid = (s_q.st == ST_OUT);
    assign out_class = cls_fin;
    assign out_size  = size_fin;
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker
    import rsd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode64,
    input logic              in_ready,
    input logic              out_valid,
    input logic [CLS_W-1:0]  out_class,
    input logic [1:0]        out_size,
    input logic [SPEC_W-1:0] out_reg,
    input logic [SPEC_W-1:0] out_base,
    input logic [SPEC_W-1:0] out_index,
    input logic              out_sib
);
    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid) else $error("result held too long"); // R11

    AST_RESULT_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready) else $error("ready during result"); // R11

    AST_BYTE_OP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 4'd2) |-> out_size == 2'd0) else $error("byte op size"); // R5

    AST_LEGACY_NO_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mode64) |-> (out_size != 2'd3 && !out_reg[SPEC_W-1] &&
        !out_base[SPEC_W-1] && !out_index[SPEC_W-1])) else $error("legacy widened"); // R2

    AST_INDEX_NEEDS_SIB: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sib) |-> out_index == '0) else $error("index without sib"); // R7

    AST_GROUP_REG_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_class == 4'd6 || out_class == 4'd7)) |-> !out_reg[SPEC_W-1])
        else $error("extension field widened"); // R6

    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 4'd8) |-> (out_size == 2'd0 && out_reg == '0 &&
        out_base == '0 && out_index == '0 && !out_sib)) else $error("bad not zero"); // R12
endmodule

bind rsd_decoder rsd_checker u_chk (.*);

// File: tb/sim_rsd_decoder.sv
module sim_rsd_decoder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode64 = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, out_valid, out_sib;
    logic [3:0] out_class, out_reg, out_base, out_index;
    logic [1:0] out_size;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int cls; int sz; int rg; int bs; int ix; int sb;
    } exp_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .mode64(mode64), .in_valid(in_valid),
        .in_byte(in_byte), .in_ready(in_ready), .out_valid(out_valid),
        .out_class(out_class), .out_size(out_size), .out_reg(out_reg),
        .out_base(out_base), .out_index(out_index), .out_sib(out_sib)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input bit m64, input logic [7:0] s[8]);
        exp_t e;
        int i = 0;
        bit osz = 0, w = 0, r = 0, x = 0, b = 0;
        logic [7:0] op, fm, sb;
        bit has;
        int sz;
        e = '{8, 0, 0, 0, 0, 0};
        while (i < 6 && (s[i] == 8'h66 || (m64 && s[i][7:4] == 4'h4))) begin
            if (s[i] == 8'h66) begin osz = 1; w = 0; r = 0; x = 0; b = 0; end
            else begin w = s[i][3]; r = s[i][2]; x = s[i][1]; b = s[i][0]; end
            i++;
        end
        op = s[i]; i++;
        sz = w ? 3 : (osz ? 1 : 2);
        if (!m64 && op[7:4] == 4'h4) begin
            e.cls = op[3] ? 7 : 6; e.sz = sz; e.bs = int'(op[2:0]); return e;
        end
        if (op[7:3] == 5'b10111) begin
            e.cls = 5; e.sz = sz; e.bs = int'({b, op[2:0]}); return e;
        end
        case (op)
            8'h01: e.cls = 0; 8'h03: e.cls = 1; 8'h88: e.cls = 2;
            8'h89: e.cls = 3; 8'h8B: e.cls = 4; 8'hFF: e.cls = 9;
            default: return e;
        endcase
        fm = s[i]; i++;
        has = (fm[7:6] != 2'b11) && (fm[2:0] == 3'b100);
        sb = s[i];
        if (e.cls == 9) begin
            if (fm[5:3] > 3'd1) begin e.cls = 8; return e; end
            e.cls = 6 + int'(fm[5:3]);
            e.rg = int'(fm[5:3]);
        end else begin
            e.rg = int'({r, fm[5:3]});
        end
        e.sz = (op == 8'h88) ? 0 : sz;
        e.bs = has ? int'({b, sb[2:0]}) : int'({b, fm[2:0]});
        e.ix = has ? int'({x, sb[5:3]}) : 0;
        e.sb = has ? 1 : 0;
        return e;
    endfunction

    task automatic run_seq(input string tag, input bit m64, input logic [7:0] s[8],
                           input int n, input exp_t e);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) mode64 = m64;
            cmp({tag, " R11 ready/idle before byte"}, int'({in_ready, out_valid}), 2);
            in_valid = 1'b1;
            in_byte  = s[i];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        cmp({tag, " R11 valid, ready low"}, int'({out_valid, in_ready}), 2);
        cmp({tag, " class"}, int'(out_class), e.cls);
        cmp({tag, " size"}, int'(out_size), e.sz);
        cmp({tag, " reg"}, int'(out_reg), e.rg);
        cmp({tag, " base"}, int'(out_base), e.bs);
        cmp({tag, " index"}, int'(out_index), e.ix);
        cmp({tag, " sib"}, int'(out_sib), e.sb);
        @(negedge clk);
        cmp({tag, " R11 one-cycle result"}, int'({out_valid, in_ready}), 1);
    endtask

    task automatic go(input string tag, input bit m64, input int n, input logic [63:0] pk,
                      input int c, input int sz, input int rg, input int bs,
                      input int ix, input int sb);
        logic [7:0] s[8];
        exp_t e;
        for (int i = 0; i < 8; i++) s[i] = pk[63-8*i -: 8];
        e = '{c, sz, rg, bs, ix, sb};
        run_seq(tag, m64, s, n, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] s[8];
        exp_t e;
        int n, pre, sel;
        bit m64;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R1 reset out_valid", int'(out_valid), 0);
        cmp("R1 reset in_ready", int'(in_ready), 1);
        rst_n = 1'b1;

        go("R3 W mov", 1, 3, 64'h4889C3_0000000000, 3, 3, 0, 3, 0, 0);
        go("R3 W beats 66", 1, 4, 64'h664801D8_00000000, 0, 3, 3, 0, 0, 0);
        go("R4 66 alone", 1, 3, 64'h6689C8_0000000000, 3, 1, 1, 0, 0, 0);
        go("R4 default 32", 1, 2, 64'h03C1_000000000000, 1, 2, 0, 1, 0, 0);
        go("R2 R4 legacy inc16", 0, 2, 64'h6641_000000000000, 6, 1, 0, 1, 0, 0);
        go("R2 legacy dec", 0, 1, 64'h4F_00000000000000, 7, 2, 0, 7, 0, 0);
        go("R5 byte op", 1, 3, 64'h4C88C0_0000000000, 2, 0, 8, 0, 0, 0);
        go("R6 grp inc R ignored", 1, 3, 64'h44FFC1_0000000000, 6, 2, 0, 1, 0, 0);
        go("R6 R8 grp dec B", 1, 3, 64'h49FFC9_0000000000, 7, 3, 1, 9, 0, 0);
        go("R7 R9 index X", 1, 4, 64'h428B048D_00000000, 4, 2, 0, 5, 9, 1);
        go("R8 sib base B", 1, 4, 64'h418B0424_00000000, 4, 2, 0, 12, 4, 1);
        go("R8 imm reg B", 1, 2, 64'h41BB_000000000000, 5, 2, 0, 11, 0, 0);
        go("R9 mod11 rm4 no sib", 1, 2, 64'h89E4_000000000000, 3, 2, 4, 4, 0, 0);
        go("R10 pfx then 66", 1, 4, 64'h486689C3_00000000, 3, 1, 0, 3, 0, 0);
        go("R10 last pfx wins", 1, 4, 64'h414489C3_00000000, 3, 2, 8, 3, 0, 0);
        go("R12 unsupported", 1, 1, 64'h90_00000000000000, 8, 0, 0, 0, 0, 0);
        go("R12 grp ext 2", 1, 2, 64'hFFD0_000000000000, 8, 0, 0, 0, 0, 0);

        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < 8; i++) s[i] = 8'h00;
            n = 0;
            m64 = 1'($urandom % 2);
            pre = $urandom % 6;
            if (!m64 && pre >= 2) pre = pre % 2;
            if (pre == 1 || pre == 3) begin s[n] = 8'h66; n++; end
            if (pre >= 2) begin s[n] = 8'h40 | 8'($urandom % 16); n++; end
            if (pre == 4) begin s[n] = 8'h66; n++; end
            if (pre == 5) begin s[n] = 8'h40 | 8'($urandom % 16); n++; end
            sel = $urandom % 10;
            case (sel)
                0: s[n] = 8'h01; 1: s[n] = 8'h03; 2: s[n] = 8'h88;
                3: s[n] = 8'h89; 4: s[n] = 8'h8B;
                5: s[n] = 8'hB8 | 8'($urandom % 8);
                6, 7: s[n] = 8'hFF;
                8: s[n] = m64 ? 8'hC3 : (8'h40 | 8'($urandom % 16));
                default: s[n] = 8'h90;
            endcase
            n++;
            if (sel <= 4 || sel == 6 || sel == 7) begin
                s[n] = 8'($urandom);
                if (sel >= 6) s[n][5:3] = 3'($urandom % 3);
                if (s[n][7:6] != 2'b11 && s[n][2:0] == 3'b100) begin
                    n++;
                    s[n] = 8'($urandom);
                end
                n++;
            end
            e = model(m64, s);
            run_seq("R3 R4 R6 R7 R8 R9 R10 random", m64, s, n, e);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule